// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block is the performance-monitor bank of one cache slice. It holds a set of event counters, 32 bits wide and eight by default. Each counter is steered by its own event selector to one of several one-cycle event strobes that come from the slice, or to the clock itself. Software programs and reads the bank through a plain 32-bit register port. A write takes effect on the clock edge on which `reg_wen` is high. Read data is a combinational function of `reg_addr`.

Two counters next to each other, one even and one odd, can be joined into a 64-bit counter. In that mode the odd counter counts the carry-outs of the even counter below it and ignores its own selected event. Enables and interrupt enables are changed with write-one set/clear registers, so several agents can change them without a read-modify-write. Every counter owns a sticky overflow flag that software clears by writing one to it. A counter can also be told to raise its flag on every change of its top bit, so a 32-bit counter can run free and software only has to sample it twice per wrap. One registered level interrupt reports any flag that is enabled.

Top module: `evt_count_bank`

Register map (byte addresses): 0x000 global control (bit 0 run, bit 1 clear command, write-only); 0x004 enable set; 0x008 enable clear; 0x00C interrupt-enable set; 0x010 interrupt-enable clear; 0x014 chain mask; 0x018 overflow status; 0x01C top-bit mode mask; 0x100+4n value of counter n; 0x200+4n event selector of counter n. Bit n of every mask register belongs to counter n.

## Requirements
- R1: After reset, every counter, selector, enable, interrupt enable, chain bit, top-bit mode bit and overflow flag reads zero, and the run bit and `irq` are low.
- R2: An enabled counter adds one on each clock edge where the run bit is set and its selected event fires. Code 0x01 fires every cycle. Code 0x20+k fires when `ev_pulse[k]` is high, for k from 0 to 5. Any other code never fires.
- R3: While the run bit (control bit 0) is clear, no counter changes except through a software write.
- R4: Writing a one to bit n at the enable-set address sets enable n, and writing a one at the enable-clear address clears it. Zero bits leave enables unchanged. Both addresses read back the current enable mask, and a disabled counter holds its value.
- R5: The interrupt-enable set and clear addresses follow the same write-one rules as R4 and both read back the current interrupt-enable mask.
- R6: When chain bit n is set for an odd n, counter n adds one exactly when counter n-1 steps from all ones to zero, and it ignores its own selected event. Chain bits of even counters have no effect.
- R7: A counter that steps from all ones to zero sets its overflow flag. The flag stays set until a one is written to its bit of the status register. Zero bits written to the status register leave flags unchanged.
- R8: With top-bit mode bit n set, counter n also raises its overflow flag when it steps from 0x7FFFFFFF to 0x80000000. With the bit clear, that step raises no flag.
- R9: `irq` is high in the cycle after a cycle in which any overflow flag and its interrupt enable are both set, and low otherwise.
- R10: When a counter overflows on the same edge as a write-one-to-clear of its flag, the flag ends up set.
- R11: When a software write to a counter and an increment of that counter fall on the same edge, the written value is stored. A written even counter passes no carry to a chained odd neighbour.
- R12: Writing a one to control bit 1 clears all counters, selectors, enables, interrupt enables, chain bits, top-bit mode bits, overflow flags and the run bit on that edge. The command bit always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 12 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_pulse | input | 6 | One-cycle event strobes from the cache slice |
| irq | output | 1 | Registered level interrupt |

## Verification
The properties assume that `reg_addr` is stable and meaningful whenever `reg_wen` is high, and that nothing is written to the bank in a cycle where the hold-while-stopped and sticky-flag rules are checked. Those two rules are therefore only claimed for cycles with no write. The stimulus gives each register access its own cycle, except where a collision is the point of the test. It pulses each event strobe for exactly one cycle and stops the run bit before reading a counter that counts clock cycles. Because of this, every expected counter value can be stated exactly.

// File: rtl/evt_count_bank.sv
module evt_count_bank #(
  parameter int NCNT = 8,
  parameter int CW   = 32,
  parameter int NEV  = 6,
  parameter int AW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wen,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [NEV-1:0] ev_pulse,
  output logic          irq
);
  localparam int IW = (NCNT > 1) ? $clog2(NCNT) : 1;
  localparam logic [7:0] CODE_CYC  = 8'h01;
  localparam logic [7:0] CODE_BASE = 8'h20;
  localparam logic [AW-1:0] A_CTRL = AW'(12'h000);
  localparam logic [AW-1:0] A_ENS  = AW'(12'h004);
  localparam logic [AW-1:0] A_ENC  = AW'(12'h008);
  localparam logic [AW-1:0] A_IES  = AW'(12'h00C);
  localparam logic [AW-1:0] A_IEC  = AW'(12'h010);
  localparam logic [AW-1:0] A_CHN  = AW'(12'h014);
  localparam logic [AW-1:0] A_OVF  = AW'(12'h018);
  localparam logic [AW-1:0] A_MSB  = AW'(12'h01C);

  logic                      run;
  logic [NCNT-1:0]           en, ien, gang, msbm, ovf;
  logic [NCNT-1:0][CW-1:0]   cnt, cnt_nx;
  logic [NCNT-1:0][7:0]      esel;
  logic [NCNT-1:0]           cnt_we, sel_we, inc, carry, ov_ev;
  logic                      in_cnt, in_sel, clr;
  logic [IW-1:0]             idx;
  logic [NCNT-1:0]           wmask;

  assign idx    = reg_addr[IW+1:2];
  assign in_cnt = reg_addr[AW-1:8] == (AW-8)'(1) && reg_addr[1:0] == 2'b00 &&
                  reg_addr[7:2] < 6'(NCNT);
  assign in_sel = reg_addr[AW-1:8] == (AW-8)'(2) && reg_addr[1:0] == 2'b00 &&
                  reg_addr[7:2] < 6'(NCNT);
  assign clr    = reg_wen && reg_addr == A_CTRL && reg_wdata[1];
  assign wmask  = reg_wdata[NCNT-1:0];

  for (genvar n = 0; n < NCNT; n++) begin : g_cnt
    logic evt;
    logic hit;
    always_comb begin
      evt = (esel[n] == CODE_CYC);
      for (int k = 0; k < NEV; k++)
        if (esel[n] == CODE_BASE + 8'(k) && ev_pulse[k]) evt = 1'b1;
    end
    assign cnt_we[n] = reg_wen && in_cnt && idx == IW'(n);
    assign sel_we[n] = reg_wen && in_sel && idx == IW'(n);
    if (n % 2 == 1) begin : g_odd
      assign hit      = gang[n] ? carry[n-1] : evt;
      assign carry[n] = 1'b0;
    end else begin : g_even
      assign hit      = evt;
      assign carry[n] = run && en[n] && evt && !cnt_we[n] && (&cnt[n]);
    end
    assign inc[n]   = run && en[n] && hit && !cnt_we[n];
    assign ov_ev[n] = inc[n] && ((&cnt[n]) || (msbm[n] && (&cnt[n][CW-2:0])));
    assign cnt_nx[n] = cnt_we[n] ? reg_wdata[CW-1:0] :
                       inc[n]    ? cnt[n] + CW'(1)   : cnt[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      en   <= '0;
      ien  <= '0;
      gang <= '0;
      msbm <= '0;
      ovf  <= '0;
      cnt  <= '0;
      esel <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= |(ovf & ien);
      if (clr) begin
        run  <= 1'b0;
        en   <= '0;
        ien  <= '0;
        gang <= '0;
        msbm <= '0;
        ovf  <= '0;
        cnt  <= '0;
        esel <= '0;
      end else begin
        cnt <= cnt_nx;
        for (int n = 0; n < NCNT; n++)
          if (sel_we[n]) esel[n] <= reg_wdata[7:0];
        if (reg_wen && reg_addr == A_CTRL) run <= reg_wdata[0];
        if (reg_wen && reg_addr == A_ENS) en  <= en | wmask;
        if (reg_wen && reg_addr == A_ENC) en  <= en & ~wmask;
        if (reg_wen && reg_addr == A_IES) ien <= ien | wmask;
        if (reg_wen && reg_addr == A_IEC) ien <= ien & ~wmask;
        if (reg_wen && reg_addr == A_CHN) gang <= wmask;
        if (reg_wen && reg_addr == A_MSB) msbm <= wmask;
        ovf <= (ovf & ~((reg_wen && reg_addr == A_OVF) ? wmask : '0)) | ov_ev;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:       reg_rdata[0] = run;
      A_ENS, A_ENC: reg_rdata[NCNT-1:0] = en;
      A_IES, A_IEC: reg_rdata[NCNT-1:0] = ien;
      A_CHN:        reg_rdata[NCNT-1:0] = gang;
      A_OVF:        reg_rdata[NCNT-1:0] = ovf;
      A_MSB:        reg_rdata[NCNT-1:0] = msbm;
      default: begin
        if (in_cnt) reg_rdata[CW-1:0] = cnt[idx];
        if (in_sel) reg_rdata[7:0]    = esel[idx];
      end
    endcase
  end
endmodule

// File: rtl/evt_count_bank_chk.sv
module evt_count_bank_chk #(
  parameter int NCNT = 8,
  parameter int CW   = 32,
  parameter int AW   = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wen,
  input logic [AW-1:0]           reg_addr,
  input logic [31:0]             reg_wdata,
  input logic                    run,
  input logic [NCNT-1:0]         en,
  input logic [NCNT-1:0]         ien,
  input logic [NCNT-1:0]         ovf,
  input logic [NCNT-1:0][CW-1:0] cnt,
  input logic                    irq
);
  localparam logic [AW-1:0] C_CTRL = AW'(12'h000);
  localparam logic [AW-1:0] C_ENS  = AW'(12'h004);
  localparam logic [AW-1:0] C_OVF  = AW'(12'h018);

  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_wen) |=> $stable(cnt));

  p_enset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == C_ENS) |=>
      ((en & $past(reg_wdata[NCNT-1:0])) == $past(reg_wdata[NCNT-1:0])));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == C_OVF && !run) |=>
      ((ovf & $past(reg_wdata[NCNT-1:0])) == '0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wen) |=> ((ovf & $past(ovf)) == $past(ovf)));

  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf & ien)) |=> irq);

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(ovf & ien))) |=> !irq);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == C_CTRL && reg_wdata[1]) |=>
      (cnt == '0 && en == '0 && ien == '0 && ovf == '0 && !run));
endmodule

bind evt_count_bank evt_count_bank_chk #(.NCNT(NCNT), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .run(run), .en(en), .ien(ien), .ovf(ovf),
  .cnt(cnt), .irq(irq)
);

// File: tb/tb_evt_count_bank.sv
module tb_evt_count_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  ev_pulse = '0;
  logic        irq;

  evt_count_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse), .irq(irq)
  );

  always #4 clk = ~clk;

  localparam logic [11:0] CTRL = 12'h000, ENS = 12'h004, ENC = 12'h008,
                          IES = 12'h00C, IEC = 12'h010, CHN = 12'h014,
                          OVF = 12'h018, MSB = 12'h01C, IRQPIN = 12'hFFF;

  typedef struct {
    logic [11:0] a;
    logic [31:0] v;
    string       tag;
  } exp_t;

  exp_t        q[$];
  exp_t        cur;
  logic [31:0] got;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  function automatic logic [11:0] cnt_a(int n);
    return 12'h100 + 12'(4 * n);
  endfunction
  function automatic logic [11:0] sel_a(int n);
    return 12'h200 + 12'(4 * n);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(posedge clk); #1;
    ev_pulse = m;
    @(posedge clk); #1;
    ev_pulse = '0;
  endtask

  task automatic wr_pulse(input logic [11:0] a, input logic [31:0] d, input logic [5:0] m);
    @(posedge clk); #1;
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d; ev_pulse = m;
    @(posedge clk); #1;
    reg_wen = 1'b0; ev_pulse = '0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    @(posedge clk); #1;
    reg_addr = a;
    e.a = a; e.v = v; e.tag = tag;
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      got = (cur.a == IRQPIN) ? {31'b0, irq} : reg_rdata;
      checks++;
      if (got !== cur.v) begin
        errors++;
        $display("FAIL %s got %h exp %h", cur.tag, got, cur.v);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got %h exp %h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    expect_rd(CTRL, 32'h0, "R1 ctrl");
    expect_rd(ENS, 32'h0, "R1 enable");
    expect_rd(cnt_a(5), 32'h0, "R1 counter");
    expect_rd(OVF, 32'h0, "R1 status");
    expect_rd(IRQPIN, 32'h0, "R1 irq");

    wr(sel_a(0), 32'h20);
    wr(sel_a(1), 32'h22);
    wr(sel_a(2), 32'h01);
    wr(sel_a(3), 32'h07);
    wr(ENS, 32'h0F);
    wr(CTRL, 32'h1);
    wr(CTRL, 32'h0);
    expect_rd(cnt_a(2), 32'd2, "R2 cycle code");
    wr(sel_a(2), 32'h23);
    pulse(6'h01);
    expect_rd(cnt_a(0), 32'd0, "R3 stopped");
    wr(CTRL, 32'h1);
    pulse(6'h01); pulse(6'h01); pulse(6'h01);
    pulse(6'h04); pulse(6'h04);
    pulse(6'h3F);
    expect_rd(cnt_a(0), 32'd4, "R2 code 0x20");
    expect_rd(cnt_a(1), 32'd3, "R2 code 0x22");
    expect_rd(cnt_a(3), 32'd0, "R2 unused code");

    wr(ENC, 32'h02);
    expect_rd(ENS, 32'h0D, "R4 set addr readback");
    expect_rd(ENC, 32'h0D, "R4 clear addr readback");
    pulse(6'h04);
    expect_rd(cnt_a(1), 32'd3, "R4 disabled holds");

    wr(cnt_a(0), 32'hFFFF_FFFE);
    pulse(6'h01);
    expect_rd(OVF, 32'h0, "R7 no flag before wrap");
    pulse(6'h01);
    expect_rd(cnt_a(0), 32'h0, "R7 wrapped");
    expect_rd(OVF, 32'h01, "R7 flag set");
    expect_rd(IRQPIN, 32'h0, "R9 masked");
    wr(IES, 32'h01);
    expect_rd(IRQPIN, 32'h1, "R9 raised");
    wr(OVF, 32'h00);
    expect_rd(OVF, 32'h01, "R7 zero write");
    wr(OVF, 32'h01);
    expect_rd(OVF, 32'h0, "R7 cleared");
    expect_rd(IRQPIN, 32'h0, "R9 dropped");

    wr(IES, 32'h04);
    expect_rd(IES, 32'h05, "R5 set");
    expect_rd(IEC, 32'h05, "R5 clear addr readback");
    wr(IEC, 32'h01);
    expect_rd(IES, 32'h04, "R5 clear");

    wr(cnt_a(0), 32'hFFFF_FFFF);
    wr_pulse(OVF, 32'h01, 6'h01);
    expect_rd(OVF, 32'h01, "R10 overflow wins");
    expect_rd(cnt_a(0), 32'h0, "R10 counter");
    wr(OVF, 32'h01);

    wr(CHN, 32'h02);
    wr(ENS, 32'h02);
    wr(cnt_a(1), 32'h0);
    wr(cnt_a(0), 32'hFFFF_FFFF);
    wr_pulse(cnt_a(0), 32'h10, 6'h01);
    expect_rd(cnt_a(0), 32'h10, "R11 write wins");
    expect_rd(cnt_a(1), 32'h0, "R11 no carry");
    expect_rd(OVF, 32'h0, "R11 no flag");

    wr(cnt_a(0), 32'hFFFF_FFFF);
    pulse(6'h01);
    expect_rd(cnt_a(0), 32'h0, "R6 low half");
    expect_rd(cnt_a(1), 32'h1, "R6 high half");
    pulse(6'h04);
    expect_rd(cnt_a(1), 32'h1, "R6 own event ignored");
    wr(OVF, 32'hFF);

    wr(MSB, 32'h04);
    wr(cnt_a(2), 32'h7FFF_FFFF);
    pulse(6'h08);
    expect_rd(OVF, 32'h04, "R8 rising msb");
    expect_rd(IRQPIN, 32'h1, "R9 bit2");
    wr(OVF, 32'h04);
    pulse(6'h08);
    expect_rd(OVF, 32'h0, "R8 no toggle");
    wr(cnt_a(2), 32'hFFFF_FFFF);
    pulse(6'h08);
    expect_rd(OVF, 32'h04, "R8 falling msb");
    wr(OVF, 32'h04);
    wr(cnt_a(0), 32'h7FFF_FFFF);
    pulse(6'h01);
    expect_rd(OVF, 32'h0, "R8 mode off");

    wr(CTRL, 32'h3);
    expect_rd(CTRL, 32'h0, "R12 ctrl");
    expect_rd(cnt_a(0), 32'h0, "R12 counter");
    expect_rd(cnt_a(1), 32'h0, "R12 odd counter");
    expect_rd(ENS, 32'h0, "R12 enables");
    expect_rd(IES, 32'h0, "R12 irq enables");
    expect_rd(CHN, 32'h0, "R12 chain");
    expect_rd(MSB, 32'h0, "R12 msb mode");
    expect_rd(sel_a(1), 32'h0, "R12 selector");
    expect_rd(OVF, 32'h0, "R12 status");

    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule